// File: doc/BRIEF.md
# Byte-Addressed Load/Store Unit

This unit sits between an execute stage and a 16-bit data memory that covers a 64 KB byte-addressed space. It adds a small signed offset to a base value to form the effective address. For stores it works out the word address, the byte enables and the data to place on each byte lane. For loads it picks the addressed byte out of the returned word and extends it, or it passes the whole word through. Word accesses to odd addresses are refused with a fault. Accesses to the top 4 KB go to a separate memory-mapped I/O port, and everything below that goes to the RAM port.

The unit handles one access at a time. When it accepts a request it raises `busy` and sends a single-cycle request on the selected port. It then waits for that port's acknowledge and, in the cycle after it, returns a single-cycle response. A faulting access never reaches either port. Its fault response comes in the cycle after the request.

Top module: `byte_lsu`

## Requirements
- R1: The effective address is `req_base` plus `req_off` sign-extended from 4 bits, modulo 2^16. The port address is the effective address with bit 0 dropped.
- R2: An effective address of 0xF000 or above requests the I/O port only. A lower address requests the RAM port only. The two port requests are never high together.
- R3: A byte store (`req_op` = 3'b100) sets `we`. It drives the low byte of `req_wdata` onto both halves of the port write data. Its byte enables are 2'b01 for an even address and 2'b10 for an odd one.
- R4: A word store (`req_op` = 3'b101) sets `we`, drives all 16 bits of `req_wdata` and uses byte enables 2'b11.
- R5: A signed byte load (`req_op` = 3'b000) returns the addressed byte sign-extended to 16 bits. Little-endian order applies: bits 7:0 of a word are its even address and bits 15:8 its odd address.
- R6: An unsigned byte load (`req_op` = 3'b010) returns the addressed byte with the upper 8 bits zero.
- R7: A word load (`req_op` = 3'b001 or 3'b011) returns the whole 16-bit word from the port.
- R8: A word access (`req_op` bit 0 set) at an odd address raises no port request and performs no write. It produces `rsp_valid` with `rsp_fault` for one cycle, in the cycle after the request, and `busy` stays low. Byte accesses at odd addresses never fault.
- R9: `busy` rises in the cycle after a request is accepted and falls together with the response. A `req_valid` seen while `busy` is high is ignored.
- R10: The response comes in the cycle after the selected port's acknowledge. An acknowledge from the other port, or one that arrives while idle, is ignored. Store responses carry zero data.
- R11: After reset, `busy`, `rsp_valid`, `rsp_fault`, `ram_req` and `io_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_op | input | 3 | bit2 store, bit0 word, bit1 unsigned (byte loads) |
| req_base | input | 16 | Base address |
| req_off | input | 4 | Signed offset |
| req_wdata | input | 16 | Store data |
| busy | output | 1 | Access in flight |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 16 | Load result |
| rsp_fault | output | 1 | Misaligned word access |
| ram_req | output | 1 | RAM request pulse |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 15 | RAM word address |
| ram_be | output | 2 | RAM byte enables |
| ram_wdata | output | 16 | RAM write data |
| ram_ack | input | 1 | RAM acknowledge |
| ram_rdata | input | 16 | RAM read data |
| io_req | output | 1 | I/O request pulse |
| io_we | output | 1 | I/O write enable |
| io_addr | output | 15 | I/O word address |
| io_be | output | 2 | I/O byte enables |
| io_wdata | output | 16 | I/O write data |
| io_ack | input | 1 | I/O acknowledge |
| io_rdata | input | 16 | I/O read data |

## Verification
The bench covers the following corner cases:
- **Region boundary.** It accesses addresses on both sides of 0xF000, and one offset that wraps past 0xFFFF. A wrong region compare or a missing wrap sends the access to the wrong port or the wrong word.
- **Byte lanes.** It stores and loads bytes at odd and even addresses, using values with bit 7 set and clear. Swapped lanes or wrong extension show up as corrupted neighbour bytes or wrong upper bits.
- **Misaligned words.** It checks that these return a fault and leave memory untouched.
- **Ignored inputs.** It sends a request while busy and a stray acknowledge from the idle port. A design that accepts either would produce an unexpected port access or an early response.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  // request opcode bit meanings
  localparam int OP_WORD_BIT  = 0;
  localparam int OP_UNS_BIT   = 1;
  localparam int OP_STORE_BIT = 2;

  typedef enum logic [2:0] {
    OP_LD_BS = 3'b000,
    OP_LD_W  = 3'b001,
    OP_LD_BU = 3'b010,
    OP_ST_B  = 3'b100,
    OP_ST_W  = 3'b101
  } lsu_op_e;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4,
  parameter int LANE_W = 1,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'hF000
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  off,
  input  logic              is_word,
  output logic [ADDR_W-1:0] ea,
  output logic              is_io,
  output logic              misal
);
  logic [ADDR_W-1:0] off_ext;
  assign off_ext = {{(ADDR_W-OFF_W){off[OFF_W-1]}}, off};
  assign ea      = base + off_ext;
  assign is_io   = (ea >= IO_BASE);
  assign misal   = is_word && (ea[LANE_W-1:0] != '0);
endmodule

// File: rtl/lsu_wfmt.sv
module lsu_wfmt #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int LANES  = DATA_W / BYTE_W,
  parameter int LANE_W = 1
) (
  input  logic [DATA_W-1:0] data_in,
  input  logic [LANE_W-1:0] lane,
  input  logic              is_word,
  output logic [DATA_W-1:0] data_out,
  output logic [LANES-1:0]  be
);
  localparam logic [LANES-1:0] ONE_LANE = LANES'(1);

  always_comb begin
    if (is_word) begin
      data_out = data_in;
      be       = '1;
    end else begin
      data_out = {LANES{data_in[BYTE_W-1:0]}};
      be       = ONE_LANE << lane;
    end
  end
endmodule

// File: rtl/lsu_rfmt.sv
module lsu_rfmt #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int LANE_W = 1
) (
  input  logic [DATA_W-1:0] word_in,
  input  logic [LANE_W-1:0] lane,
  input  logic              is_word,
  input  logic              is_uns,
  input  logic              is_store,
  output logic [DATA_W-1:0] data_out
);
  logic [BYTE_W-1:0] sel_byte;
  logic              fill;

  assign sel_byte = word_in[lane*BYTE_W +: BYTE_W];
  assign fill     = is_uns ? 1'b0 : sel_byte[BYTE_W-1];

  always_comb begin
    if (is_store)     data_out = '0;
    else if (is_word) data_out = word_in;
    else              data_out = {{(DATA_W-BYTE_W){fill}}, sel_byte};
  end
endmodule

// File: rtl/byte_lsu.sv
module byte_lsu #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int OFF_W  = 4,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'hF000,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WADDR_W = ADDR_W - LANE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [2:0]         req_op,
  input  logic [ADDR_W-1:0]  req_base,
  input  logic [OFF_W-1:0]   req_off,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               busy,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_fault,
  output logic               ram_req,
  output logic               ram_we,
  output logic [WADDR_W-1:0] ram_addr,
  output logic [LANES-1:0]   ram_be,
  output logic [DATA_W-1:0]  ram_wdata,
  input  logic               ram_ack,
  input  logic [DATA_W-1:0]  ram_rdata,
  output logic               io_req,
  output logic               io_we,
  output logic [WADDR_W-1:0] io_addr,
  output logic [LANES-1:0]   io_be,
  output logic [DATA_W-1:0]  io_wdata,
  input  logic               io_ack,
  input  logic [DATA_W-1:0]  io_rdata
);
  import lsu_pkg::*;

  logic              op_word, op_uns, op_store;
  logic [ADDR_W-1:0] ea;
  logic              ea_io, ea_misal;
  logic [DATA_W-1:0] st_data;
  logic [LANES-1:0]  st_be;
  logic              accept;

  assign op_word  = req_op[OP_WORD_BIT];
  assign op_uns   = req_op[OP_UNS_BIT];
  assign op_store = req_op[OP_STORE_BIT];
  assign accept   = req_valid && !busy_q;

  lsu_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANE_W(LANE_W), .IO_BASE(IO_BASE)) u_agen (
    .base(req_base), .off(req_off), .is_word(op_word),
    .ea(ea), .is_io(ea_io), .misal(ea_misal)
  );

  lsu_wfmt #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .LANES(LANES), .LANE_W(LANE_W)) u_wfmt (
    .data_in(req_wdata), .lane(ea[LANE_W-1:0]), .is_word(op_word),
    .data_out(st_data), .be(st_be)
  );

  // registered access state
  logic               busy_q, sel_io_q, store_q, word_q, uns_q;
  logic [LANE_W-1:0]  lane_q;
  logic [WADDR_W-1:0] addr_q;
  logic [LANES-1:0]   be_q;
  logic [DATA_W-1:0]  wd_q;
  logic               ram_req_q, io_req_q;
  logic               rsp_valid_q, rsp_fault_q;
  logic [DATA_W-1:0]  rsp_data_q;

  logic [DATA_W-1:0] port_rdata, ld_data;
  logic              port_ack;
  assign port_rdata = sel_io_q ? io_rdata : ram_rdata;
  assign port_ack   = sel_io_q ? io_ack : ram_ack;

  lsu_rfmt #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .LANE_W(LANE_W)) u_rfmt (
    .word_in(port_rdata), .lane(lane_q), .is_word(word_q), .is_uns(uns_q),
    .is_store(store_q), .data_out(ld_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      sel_io_q    <= 1'b0;
      store_q     <= 1'b0;
      word_q      <= 1'b0;
      uns_q       <= 1'b0;
      lane_q      <= '0;
      addr_q      <= '0;
      be_q        <= '0;
      wd_q        <= '0;
      ram_req_q   <= 1'b0;
      io_req_q    <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      ram_req_q   <= 1'b0;
      io_req_q    <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      if (accept) begin
        if (ea_misal) begin
          rsp_valid_q <= 1'b1;
          rsp_fault_q <= 1'b1;
          rsp_data_q  <= '0;
        end else begin
          busy_q    <= 1'b1;
          sel_io_q  <= ea_io;
          store_q   <= op_store;
          word_q    <= op_word;
          uns_q     <= op_uns;
          lane_q    <= ea[LANE_W-1:0];
          addr_q    <= ea[ADDR_W-1:LANE_W];
          be_q      <= st_be;
          wd_q      <= op_store ? st_data : '0;
          ram_req_q <= !ea_io;
          io_req_q  <= ea_io;
        end
      end else if (busy_q && port_ack) begin
        busy_q      <= 1'b0;
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= ld_data;
      end
    end
  end

  assign busy      = busy_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_fault = rsp_fault_q;
  assign rsp_rdata = rsp_data_q;
  assign ram_req   = ram_req_q;
  assign ram_we    = store_q;
  assign ram_addr  = addr_q;
  assign ram_be    = be_q;
  assign ram_wdata = wd_q;
  assign io_req    = io_req_q;
  assign io_we     = store_q;
  assign io_addr   = addr_q;
  assign io_be     = be_q;
  assign io_wdata  = wd_q;

  // R2: at most one port requested
  a_r2_one_port: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_req, io_req}));
  // R9: port request implies busy, and lasts one cycle
  a_r9_req_busy: assert property (@(posedge clk) disable iff (rst)
    (ram_req || io_req) |-> busy);
  a_r9_req_pulse: assert property (@(posedge clk) disable iff (rst)
    (ram_req || io_req) |=> !(ram_req || io_req));
  // R8: fault responses never hold the unit busy
  a_r8_fault_idle: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_valid && !busy && !ram_req && !io_req));
  // R10: a normal response ends a busy period
  a_r10_rsp_end: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> (!busy && $past(busy)));
  // R3: every request enables at least one lane
  a_r3_be_nonzero: assert property (@(posedge clk) disable iff (rst)
    (ram_req || io_req) |-> (ram_be != '0));
endmodule

// File: tb/byte_lsu_bench.sv
module byte_lsu_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [15:0] req_base = '0;
  logic [3:0]  req_off = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, rsp_valid, rsp_fault;
  logic [15:0] rsp_rdata;
  logic        ram_req, ram_we, io_req, io_we;
  logic [14:0] ram_addr, io_addr;
  logic [1:0]  ram_be, io_be;
  logic [15:0] ram_wdata, io_wdata;
  logic        ram_ack = 1'b0, io_ack_r = 1'b0, stray_io = 1'b0;
  logic        io_ack;
  logic [15:0] ram_rdata = '0, io_rdata = '0;
  assign io_ack = io_ack_r | stray_io;

  byte_lsu u_byte_lsu (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_base(req_base), .req_off(req_off), .req_wdata(req_wdata),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault),
    .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr), .ram_be(ram_be),
    .ram_wdata(ram_wdata), .ram_ack(ram_ack), .ram_rdata(ram_rdata),
    .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .io_be(io_be),
    .io_wdata(io_wdata), .io_ack(io_ack), .io_rdata(io_rdata)
  );

  int tests = 0, fails = 0;
  int lat = 1;

  typedef struct { logic [15:0] data; logic fault; logic io; string tag; } rsp_t;
  typedef struct { logic io; logic we; logic [14:0] addr; logic [1:0] be; logic [15:0] wd; string tag; } port_t;
  rsp_t  rsp_q[$];
  port_t port_q[$];

  logic [15:0] ram_m [256];
  logic [15:0] io_m  [16];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rd_model(input logic io, input logic [14:0] wa);
    return io ? io_m[wa[3:0]] : ram_m[wa[7:0]];
  endfunction

  // driver: computes expectations from the requirements and issues one access
  task automatic issue(input logic [2:0] op, input logic [15:0] base, input logic [3:0] off,
                       input logic [15:0] wd, input string tag, input bit wait_done);
    logic [15:0] ea;
    logic io, word, st, uns, odd;
    logic [15:0] w, exp_d;
    logic [7:0] b;
    port_t p;
    rsp_t r;
    ea = base + {{12{off[3]}}, off};
    io = (ea >= 16'hF000);
    word = op[0]; uns = op[1]; st = op[2]; odd = ea[0];
    r.tag = tag; r.io = io;
    if (word && odd) begin
      r.fault = 1'b1; r.data = '0;
    end else begin
      p.io = io; p.we = st; p.addr = ea[15:1]; p.tag = tag;
      p.be = word ? 2'b11 : (odd ? 2'b10 : 2'b01);
      p.wd = word ? wd : {2{wd[7:0]}};
      port_q.push_back(p);
      w = rd_model(io, ea[15:1]);
      b = odd ? w[15:8] : w[7:0];
      if (st) exp_d = '0;
      else if (word) exp_d = w;
      else exp_d = uns ? {8'h00, b} : {{8{b[7]}}, b};
      r.fault = 1'b0; r.data = exp_d;
    end
    rsp_q.push_back(r);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_base = base; req_off = off; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (wait_done) while (rsp_q.size() > 0) @(negedge clk);
  endtask

  // port responder and port-side checks
  initial begin
    forever begin
      @(negedge clk);
      if (ram_req || io_req) begin
        port_t p;
        logic pio;
        logic [14:0] pa;
        logic [1:0] pbe;
        logic pwe;
        logic [15:0] pwd, old;
        pio = io_req;
        pa  = pio ? io_addr : ram_addr;
        pbe = pio ? io_be : ram_be;
        pwe = pio ? io_we : ram_we;
        pwd = pio ? io_wdata : ram_wdata;
        if (port_q.size() == 0) begin
          chk(1'b0, "R9 unexpected port request", {16'h0, pa, pio}, 32'h0);
        end else begin
          p = port_q.pop_front();
          chk(pio == p.io, {p.tag, " R2 port select"}, pio, p.io);
          chk(pa == p.addr, {p.tag, " R1 word address"}, pa, p.addr);
          chk(pwe == p.we && pbe == p.be, {p.tag, " R3/R4 we and be"}, {pwe, pbe}, {p.we, p.be});
          if (p.we) chk(pwd == p.wd, {p.tag, " R3/R4 write data"}, pwd, p.wd);
        end
        if (pwe) begin
          old = rd_model(pio, pa);
          if (pbe[0]) old[7:0] = pwd[7:0];
          if (pbe[1]) old[15:8] = pwd[15:8];
          if (pio) io_m[pa[3:0]] = old; else ram_m[pa[7:0]] = old;
        end
        repeat (lat - 1) @(negedge clk);
        if (pio) begin io_rdata = rd_model(1'b1, pa); io_ack_r = 1'b1; end
        else     begin ram_rdata = rd_model(1'b0, pa); ram_ack = 1'b1; end
        @(negedge clk);
        io_ack_r = 1'b0; ram_ack = 1'b0;
      end
    end
  end

  // monitor: pops the scoreboard as responses appear
  initial begin
    forever begin
      @(posedge clk); #1;
      if (!rst && rsp_valid) begin
        rsp_t r;
        if (rsp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected response", rsp_rdata, 32'h0);
        end else begin
          r = rsp_q.pop_front();
          chk(rsp_fault == r.fault, {r.tag, " R8 fault flag"}, rsp_fault, r.fault);
          chk(rsp_rdata == r.data, {r.tag, " R5/R6/R7 data"}, rsp_rdata, r.data);
          if (r.fault) chk(!busy, {r.tag, " R8 busy low"}, busy, 1'b0);
          else chk((r.io ? io_ack : ram_ack) == 1'b1, {r.tag, " R10 ack timing"}, 1'b0, 1'b1);
        end
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ram_m[i] = 16'(i * 16'h0101) ^ 16'h5A00;
    for (int i = 0; i < 16; i++) io_m[i] = 16'hC000 + 16'(i);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk({busy, rsp_valid, rsp_fault, ram_req, io_req} == 5'b0, "R11 reset outputs",
        {busy, rsp_valid, rsp_fault, ram_req, io_req}, 0);
    rst = 1'b0;
    @(negedge clk);

    issue(3'b101, 16'h0104, 4'hC, 16'hBEEF, "R4 SW ram", 1);
    issue(3'b001, 16'h0100, 4'h0, 16'h0, "R7 LW ram", 1);
    issue(3'b100, 16'h00FF, 4'h2, 16'h1280, "R3 SB odd", 1);
    issue(3'b001, 16'h0100, 4'h0, 16'h0, "R3 neighbour kept", 1);
    issue(3'b000, 16'h0101, 4'h0, 16'h0, "R5 LB odd neg", 1);
    issue(3'b010, 16'h0101, 4'h0, 16'h0, "R6 LBU odd", 1);
    issue(3'b000, 16'h0100, 4'h0, 16'h0, "R5 LB even neg", 1);
    issue(3'b010, 16'h0100, 4'h0, 16'h0, "R6 LBU even", 1);
    issue(3'b100, 16'h0200, 4'h0, 16'hAA7F, "R3 SB even", 1);
    issue(3'b000, 16'h0200, 4'h0, 16'h0, "R5 LB positive", 1);
    issue(3'b011, 16'h0200, 4'h0, 16'h0, "R7 LW alt code", 1);
    lat = 3;
    issue(3'b101, 16'hEFFC, 4'h4, 16'h1357, "R2 SW io base", 1);
    issue(3'b001, 16'hF000, 4'h0, 16'h0, "R2 LW io", 1);
    issue(3'b010, 16'hEFFE, 4'h1, 16'h0, "R2 LBU below io", 1);
    issue(3'b010, 16'hFFFE, 4'h7, 16'h0, "R1 wrap", 1);
    issue(3'b000, 16'hFFFF, 4'h8, 16'h0, "R1 negative offset io", 1);
    lat = 1;
    // R8 misaligned words
    issue(3'b001, 16'h0103, 4'h0, 16'h0, "R8 LW odd", 1);
    issue(3'b101, 16'hF000, 4'h1, 16'hFFFF, "R8 SW odd io", 1);
    issue(3'b001, 16'hF000, 4'h0, 16'h0, "R8 io unchanged", 1);
    issue(3'b101, 16'h0101, 4'h0, 16'h0000, "R8 SW odd ram", 1);
    issue(3'b001, 16'h0100, 4'h0, 16'h0, "R8 ram unchanged", 1);
    issue(3'b100, 16'h0303, 4'h0, 16'h0044, "R8 SB odd ok", 1);

    // R9 request while busy is ignored
    lat = 6;
    issue(3'b001, 16'h0300, 4'h0, 16'h0, "R9 long load", 0);
    chk(busy == 1'b1, "R9 busy during access", busy, 1'b1);
    req_valid = 1'b1; req_op = 3'b101; req_base = 16'h0304; req_off = 4'h0; req_wdata = 16'h1111;
    @(negedge clk); @(negedge clk);
    req_valid = 1'b0;
    while (rsp_q.size() > 0) @(negedge clk);
    lat = 1;
    issue(3'b001, 16'h0304, 4'h0, 16'h0, "R9 ignored store", 1);

    // R10 stray ack from the other port
    lat = 6;
    issue(3'b001, 16'h0100, 4'h0, 16'h0, "R10 ram load", 0);
    stray_io = 1'b1;
    @(negedge clk);
    stray_io = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1 && rsp_valid == 1'b0, "R10 stray ack ignored", {busy, rsp_valid}, 2'b10);
    while (rsp_q.size() > 0) @(negedge clk);
    lat = 1;
    stray_io = 1'b1; @(negedge clk); stray_io = 1'b0; @(negedge clk);
    chk(busy == 1'b0 && rsp_valid == 1'b0, "R10 idle ack ignored", {busy, rsp_valid}, 2'b00);

    repeat (4) @(negedge clk);
    chk(port_q.size() == 0, "R9 port queue drained", port_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule